// File: doc/BRIEF.md
# Register-Addressed Two-Wire Bus Master

This block is a master for a two-wire serial bus (SCL clock line, SDA data line). It runs single-byte write and read transactions against a slave device. Between the device address and the data byte it can place a register address of zero to three bytes. The block builds that address phase from a 24-bit value and a byte count.

A request carries a 7-bit device address, a direction, the register-address byte count, the 24-bit register address and a write byte. Software applies these and pulses a start strobe while the block is idle. The block copies every setting at that moment. It then runs the whole frame on its own: the start condition, the address bytes, the acknowledge slots, a repeated start for reads, the data byte and the stop condition.

Both lines are open drain. The block only pulls a line low through an output enable, and it reads SDA back through a separate input. When the frame ends, the block pulses done. A read returns its byte on a data output. A flag reports that some byte was refused by the slave. Slave addresses wider than 7 bits fit this scheme: the upper address bits travel in the register-address bytes.

Top module: `regbus_master`

## Requirements
- R1: While idle, busy_o is low and both output enables are low. A start request is taken only while idle. A request made while busy has no effect on the bus, and no second frame follows.
- R2: SDA changes only while SCL is low. There are two exceptions: a start condition, in which SDA falls while SCL is high, and a stop condition, in which SDA rises while SCL is high.
- R3: A write sends a start, then the byte {dev_addr_i, 0}, then the register-address bytes, then wdata_i, then a stop. Each byte is sent MSB first and is followed by an acknowledge slot in which the master releases SDA.
- R4: When iadr_size_i is N, the register-address phase sends exactly the lowest N bytes of iadr_i, highest of those first: bits 23:16, then 15:8, then 7:0. When N is 0, no register-address byte is sent.
- R5: A read with N > 0 sends {dev_addr_i, 0} and the N register-address bytes. It then sends a repeated start, then {dev_addr_i, 1}, receives one byte, and ends with a stop. The frame contains two start conditions.
- R6: A read with N = 0 sends one start, {dev_addr_i, 1}, the received byte and a stop, with no repeated start.
- R7: On a read, the received byte is taken MSB first and is shown on rdata_o once the transaction ends. The master leaves SDA released (NACK) in the ninth clock of that byte.
- R8: If the slave leaves SDA high in the acknowledge slot of any sent byte, the master skips the rest of the frame and sends a stop. It then sets nack_err_o and leaves rdata_o unchanged. nack_err_o stays set until the next start request is accepted, which clears it.
- R9: done_o is a single-cycle pulse in the cycle the stop condition completes. busy_o is low in that same cycle.
- R10: Each SCL bit period lasts 4 × (clk_div_i + 1) clock cycles.
- R11: All request inputs are captured when the start is accepted. Changing them later has no effect on the frame in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start request, taken while idle |
| rd_i | input | 1 | 1 = read, 0 = write |
| dev_addr_i | input | 7 | Device address |
| iadr_size_i | input | 2 | Number of register-address bytes (0 to 3) |
| iadr_i | input | 24 | Register address value |
| wdata_i | input | 8 | Byte to write |
| clk_div_i | input | DIV_W | Quarter-bit length minus one, in clock cycles |
| scl_oe_o | output | 1 | Pull SCL low |
| sda_oe_o | output | 1 | Pull SDA low |
| sda_i | input | 1 | SDA line level |
| busy_o | output | 1 | Transaction in progress |
| done_o | output | 1 | One-cycle end-of-transaction pulse |
| nack_err_o | output | 1 | Sticky refused-byte flag |
| rdata_o | output | 8 | Last byte read |

## Verification
Several behaviours are checked on every cycle: the bus is released while idle, SDA moves under a high SCL only inside start and stop conditions, done lasts one cycle and coincides with idle, and the error flag holds until the next accepted request. The bench uses a behavioural slave on the wired-AND lines. Only the bench's scenarios can show the other behaviours: the order and content of the bytes for every register-address size, the repeated start for reads, the received byte, truncation on a refused byte, the bit period, the capture of the inputs at start, and that a request made while busy is ignored.

// File: rtl/rbm_pkg.sv
package rbm_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_SEND,
    ST_RECV,
    ST_RSTART,
    ST_STOP
  } rbm_state_e;

  typedef enum logic [1:0] {
    BK_DEVW,
    BK_DEVR,
    BK_IADR,
    BK_DATA
  } rbm_kind_e;
endpackage

// File: rtl/rbm_quarter.sv
module rbm_quarter #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt_q, cnt_d;

  always_comb begin
    tick_o = run_i && (cnt_q == div_i);
    if (!run_i || tick_o) cnt_d = '0;
    else                  cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/rbm_lines.sv
module rbm_lines
  import rbm_pkg::*;
(
  input  rbm_state_e state_i,
  input  logic [1:0] qtr_i,
  input  logic       bit_i,
  input  logic       ack_slot_i,
  output logic       scl_oe_o,
  output logic       sda_oe_o
);
  logic edge_low;

  always_comb begin
    // In a bit cell, SCL is low in the first and last quarters.
    edge_low = (qtr_i == 2'd0) || (qtr_i == 2'd3);
    scl_oe_o = 1'b0;
    sda_oe_o = 1'b0;
    case (state_i)
      ST_START: begin
        scl_oe_o = (qtr_i == 2'd3);
        sda_oe_o = qtr_i[1];
      end
      ST_RSTART: begin
        scl_oe_o = edge_low;
        sda_oe_o = qtr_i[1];
      end
      ST_STOP: begin
        scl_oe_o = (qtr_i == 2'd0);
        sda_oe_o = !qtr_i[1];
      end
      ST_SEND: begin
        scl_oe_o = edge_low;
        sda_oe_o = !ack_slot_i && !bit_i;
      end
      ST_RECV: scl_oe_o = edge_low;
      default: ;
    endcase
  end
endmodule

// File: rtl/rbm_engine.sv
module rbm_engine
  import rbm_pkg::*;
#(
  parameter int DIV_W      = 8,
  parameter int IADR_BYTES = 3
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            start_i,
  input  logic                            rd_i,
  input  logic [6:0]                      dev_i,
  input  logic [$clog2(IADR_BYTES+1)-1:0] isz_i,
  input  logic [8*IADR_BYTES-1:0]         iadr_i,
  input  logic [7:0]                      wdata_i,
  input  logic [DIV_W-1:0]                div_i,
  input  logic                            tick_i,
  input  logic                            sda_i,
  output rbm_state_e                      state_o,
  output logic [1:0]                      qtr_o,
  output logic                            bit_o,
  output logic                            ack_slot_o,
  output logic [DIV_W-1:0]                div_o,
  output logic                            busy_o,
  output logic                            done_o,
  output logic                            nack_err_o,
  output logic [7:0]                      rdata_o
);
  localparam int LW     = $clog2(IADR_BYTES + 1);
  localparam int IADR_W = 8 * IADR_BYTES;

  rbm_state_e        state_q, state_d;
  rbm_kind_e         kind_q, kind_d;
  logic [1:0]        qtr_q, qtr_d;
  logic [3:0]        bitcnt_q, bitcnt_d;
  logic [7:0]        shreg_q, shreg_d;
  logic [LW-1:0]     left_q, left_d;
  logic              rd_q, rd_d;
  logic [6:0]        dev_q, dev_d;
  logic [IADR_W-1:0] iadr_q, iadr_d;
  logic [7:0]        wdata_q, wdata_d;
  logic [DIV_W-1:0]  div_q, div_d;
  logic              nackb_q, nackb_d;
  logic              done_q, done_d;
  logic              err_q, err_d;
  logic [7:0]        rdata_q, rdata_d;
  logic [7:0]        iad_byte;

  // Picks the register-address byte that matches the count still to send.
  always_comb begin
    iad_byte = '0;
    for (int k = 0; k < IADR_BYTES; k++)
      if (int'(left_q) == k + 1) iad_byte = iadr_q[k*8 +: 8];
  end

  always_comb begin
    state_d  = state_q;  kind_d  = kind_q;  qtr_d   = qtr_q;
    bitcnt_d = bitcnt_q; shreg_d = shreg_q; left_d  = left_q;
    rd_d     = rd_q;     dev_d   = dev_q;   iadr_d  = iadr_q;
    wdata_d  = wdata_q;  div_d   = div_q;   nackb_d = nackb_q;
    err_d    = err_q;    rdata_d = rdata_q; done_d  = 1'b0;
    if (state_q == ST_IDLE) begin
      if (start_i) begin
        rd_d = rd_i; dev_d = dev_i; left_d = isz_i; iadr_d = iadr_i;
        wdata_d = wdata_i; div_d = div_i; err_d = 1'b0;
        qtr_d = 2'd0; state_d = ST_START;
      end
    end else if (tick_i) begin
      qtr_d = qtr_q + 2'd1;
      case (state_q)
        ST_START, ST_RSTART: begin
          if (qtr_q == 2'd3) begin
            bitcnt_d = '0;
            state_d  = ST_SEND;
            if (state_q == ST_RSTART || (rd_q && left_q == '0)) begin
              shreg_d = {dev_q, 1'b1}; kind_d = BK_DEVR;
            end else begin
              shreg_d = {dev_q, 1'b0}; kind_d = BK_DEVW;
            end
          end
        end
        ST_SEND: begin
          if (qtr_q == 2'd1 && bitcnt_q == 4'd8) nackb_d = sda_i;
          if (qtr_q == 2'd3) begin
            if (bitcnt_q != 4'd8) begin
              shreg_d  = {shreg_q[6:0], 1'b0};
              bitcnt_d = bitcnt_q + 4'd1;
            end else if (nackb_q) begin
              err_d   = 1'b1;
              state_d = ST_STOP;
            end else begin
              bitcnt_d = '0;
              case (kind_q)
                BK_DEVW, BK_IADR: begin
                  if (left_q != '0) begin
                    shreg_d = iad_byte; kind_d = BK_IADR; left_d = left_q - 1'b1;
                  end else if (rd_q) begin
                    state_d = ST_RSTART;
                  end else begin
                    shreg_d = wdata_q; kind_d = BK_DATA;
                  end
                end
                BK_DEVR: state_d = ST_RECV;
                default: state_d = ST_STOP;
              endcase
            end
          end
        end
        ST_RECV: begin
          if (qtr_q == 2'd1 && bitcnt_q != 4'd8) shreg_d = {shreg_q[6:0], sda_i};
          if (qtr_q == 2'd3) begin
            if (bitcnt_q != 4'd8) bitcnt_d = bitcnt_q + 4'd1;
            else begin
              rdata_d = shreg_q;
              state_d = ST_STOP;
            end
          end
        end
        ST_STOP: begin
          if (qtr_q == 2'd3) begin
            state_d = ST_IDLE;
            done_d  = 1'b1;
          end
        end
        default: state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE; kind_q <= BK_DEVW; qtr_q <= '0; bitcnt_q <= '0;
      shreg_q <= '0; left_q <= '0; rd_q <= 1'b0; dev_q <= '0; iadr_q <= '0;
      wdata_q <= '0; div_q <= '0; nackb_q <= 1'b0; done_q <= 1'b0;
      err_q <= 1'b0; rdata_q <= '0;
    end else begin
      state_q <= state_d; kind_q <= kind_d; qtr_q <= qtr_d; bitcnt_q <= bitcnt_d;
      shreg_q <= shreg_d; left_q <= left_d; rd_q <= rd_d; dev_q <= dev_d;
      iadr_q <= iadr_d; wdata_q <= wdata_d; div_q <= div_d; nackb_q <= nackb_d;
      done_q <= done_d; err_q <= err_d; rdata_q <= rdata_d;
    end
  end

  assign state_o    = state_q;
  assign qtr_o      = qtr_q;
  assign bit_o      = shreg_q[7];
  assign ack_slot_o = (bitcnt_q == 4'd8);
  assign div_o      = div_q;
  assign busy_o     = (state_q != ST_IDLE);
  assign done_o     = done_q;
  assign nack_err_o = err_q;
  assign rdata_o    = rdata_q;
endmodule

// File: rtl/regbus_master.sv
module regbus_master
  import rbm_pkg::*;
#(
  parameter int DIV_W      = 8,
  parameter int IADR_BYTES = 3
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            start_i,
  input  logic                            rd_i,
  input  logic [6:0]                      dev_addr_i,
  input  logic [$clog2(IADR_BYTES+1)-1:0] iadr_size_i,
  input  logic [8*IADR_BYTES-1:0]         iadr_i,
  input  logic [7:0]                      wdata_i,
  input  logic [DIV_W-1:0]                clk_div_i,
  output logic                            scl_oe_o,
  output logic                            sda_oe_o,
  input  logic                            sda_i,
  output logic                            busy_o,
  output logic                            done_o,
  output logic                            nack_err_o,
  output logic [7:0]                      rdata_o
);
  logic [1:0]       rst_pipe;
  logic             rst_n_s;
  rbm_state_e       eng_state;
  logic [1:0]       eng_qtr;
  logic             eng_bit, eng_ack_slot, qtick;
  logic [DIV_W-1:0] eng_div;

  // Reset asserts at once and is released in step with the clock.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_n_s = rst_pipe[1];

  rbm_quarter #(.DIV_W(DIV_W)) u_qtr (
    .clk    (clk),
    .rst_n  (rst_n_s),
    .run_i  (busy_o),
    .div_i  (eng_div),
    .tick_o (qtick)
  );

  rbm_engine #(.DIV_W(DIV_W), .IADR_BYTES(IADR_BYTES)) u_eng (
    .clk        (clk),
    .rst_n      (rst_n_s),
    .start_i    (start_i),
    .rd_i       (rd_i),
    .dev_i      (dev_addr_i),
    .isz_i      (iadr_size_i),
    .iadr_i     (iadr_i),
    .wdata_i    (wdata_i),
    .div_i      (clk_div_i),
    .tick_i     (qtick),
    .sda_i      (sda_i),
    .state_o    (eng_state),
    .qtr_o      (eng_qtr),
    .bit_o      (eng_bit),
    .ack_slot_o (eng_ack_slot),
    .div_o      (eng_div),
    .busy_o     (busy_o),
    .done_o     (done_o),
    .nack_err_o (nack_err_o),
    .rdata_o    (rdata_o)
  );

  rbm_lines u_lines (
    .state_i    (eng_state),
    .qtr_i      (eng_qtr),
    .bit_i      (eng_bit),
    .ack_slot_i (eng_ack_slot),
    .scl_oe_o   (scl_oe_o),
    .sda_oe_o   (sda_oe_o)
  );
endmodule

// File: rtl/rbm_checker.sv
module rbm_checker
  import rbm_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       start_i,
  input logic       busy_o,
  input logic       done_o,
  input logic       nack_err_o,
  input logic       scl_oe_o,
  input logic       sda_oe_o,
  input rbm_state_e eng_state
);
  p_idle_released_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> (!scl_oe_o && !sda_oe_o));

  // R2: SDA may fall under a high SCL only as part of a start condition.
  p_sda_fall_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!scl_oe_o && $past(!scl_oe_o) && sda_oe_o && !$past(sda_oe_o))
      |-> (eng_state == ST_START || eng_state == ST_RSTART));

  // R2: SDA may rise under a high SCL only as part of a stop condition.
  p_sda_rise_stop_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!scl_oe_o && $past(!scl_oe_o) && !sda_oe_o && $past(sda_oe_o))
      |-> (eng_state == ST_STOP));

  p_done_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  p_done_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o);

  p_err_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (nack_err_o && !(start_i && !busy_o)) |=> nack_err_o);
endmodule

bind regbus_master rbm_checker u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .start_i    (start_i),
  .busy_o     (busy_o),
  .done_o     (done_o),
  .nack_err_o (nack_err_o),
  .scl_oe_o   (scl_oe_o),
  .sda_oe_o   (sda_oe_o),
  .eng_state  (eng_state)
);

// File: tb/regbus_master_tb.sv
module regbus_master_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start_i = 1'b0, rd_i = 1'b0;
  logic [6:0] dev_addr_i = '0;
  logic [1:0] iadr_size_i = '0;
  logic [23:0] iadr_i = '0;
  logic [7:0] wdata_i = '0, clk_div_i = '0;
  logic       scl_oe_o, sda_oe_o, busy_o, done_o, nack_err_o;
  logic [7:0] rdata_o;
  logic       s_drive = 1'b0;
  wire        scl_line = !scl_oe_o;
  wire        sda_line = !(sda_oe_o || s_drive);

  always #10 clk = ~clk;

  regbus_master u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .rd_i(rd_i),
    .dev_addr_i(dev_addr_i), .iadr_size_i(iadr_size_i), .iadr_i(iadr_i),
    .wdata_i(wdata_i), .clk_div_i(clk_div_i), .scl_oe_o(scl_oe_o),
    .sda_oe_o(sda_oe_o), .sda_i(sda_line), .busy_o(busy_o), .done_o(done_o),
    .nack_err_o(nack_err_o), .rdata_o(rdata_o)
  );

  int n_chk = 0, n_err = 0;
  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Behavioural slave watching the wired-AND lines.
  logic [6:0] s_addr = 7'h52;
  logic [7:0] s_txb = '0;
  int         s_nack_at = -1;
  logic       mon_clr = 1'b0;
  logic [7:0] mlog [16];
  int   log_n, n_starts, n_stops, s_bitpos, s_fidx, cyc, t_r0, t_r1;
  logic s_tx, s_tx_pend, m_ack, in_frame, prev_scl, prev_sda, sc, sd, ack;
  logic [7:0] s_sh;

  always @(negedge clk) begin
    sc = scl_line; sd = sda_line; cyc++;
    if (!rst_n || mon_clr) begin
      log_n = 0; n_starts = 0; n_stops = 0; s_drive = 1'b0; s_bitpos = 0;
      s_fidx = 0; s_tx = 1'b0; s_tx_pend = 1'b0; m_ack = 1'b0; in_frame = 1'b0;
      t_r0 = 0; t_r1 = 0; s_sh = '0;
    end else if (sc && prev_scl && prev_sda && !sd) begin
      n_starts++; in_frame = 1'b1; s_bitpos = 0; s_fidx = 0;
      s_tx = 1'b0; s_tx_pend = 1'b0; s_drive = 1'b0;
    end else if (sc && prev_scl && !prev_sda && sd) begin
      n_stops++; in_frame = 1'b0; s_drive = 1'b0; s_tx = 1'b0;
    end else if (in_frame && sc && !prev_scl) begin
      if (log_n == 0 && s_fidx == 0 && s_bitpos == 0) t_r0 = cyc;
      if (log_n == 0 && s_fidx == 0 && s_bitpos == 1) t_r1 = cyc;
      if (s_bitpos < 8) begin
        if (!s_tx) s_sh = {s_sh[6:0], sd};
      end else if (s_tx) m_ack = sd;
      s_bitpos++;
    end else if (in_frame && !sc && prev_scl) begin
      if (s_bitpos == 8) begin
        if (s_tx) s_drive = 1'b0;
        else begin
          ack = (log_n != s_nack_at) && !(s_fidx == 0 && s_sh[7:1] != s_addr);
          if (log_n < 16) mlog[log_n] = s_sh;
          log_n++;
          s_drive = ack;
          s_tx_pend = ack && (s_fidx == 0) && s_sh[0];
        end
      end else if (s_bitpos >= 9) begin
        s_bitpos = 0; s_fidx++; s_tx = s_tx_pend; s_tx_pend = 1'b0;
        s_drive = s_tx ? !s_txb[7] : 1'b0;
      end else if (s_tx && s_bitpos >= 1) s_drive = !s_txb[7 - s_bitpos];
    end
    prev_scl = sc; prev_sda = sd;
  end

  logic [7:0] prev_rdata = '0;
  logic [7:0] e [8];

  task automatic run_txn(input logic [6:0] dev, input logic rd, input int isz,
                         input logic [23:0] ia, input logic [7:0] wd, input int dv,
                         input int nack_at, input logic [7:0] txb, input bit disturb);
    int en, f, starts, w;
    bit err;
    string rq;
    s_nack_at = nack_at; s_txb = txb;
    @(posedge clk); mon_clr = 1'b1; @(posedge clk); mon_clr = 1'b0;
    @(negedge clk);
    dev_addr_i = dev; rd_i = rd; iadr_size_i = isz[1:0]; iadr_i = ia;
    wdata_i = wd; clk_div_i = dv[7:0]; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    // R11: scramble every request input once the frame has begun.
    dev_addr_i = ~dev; rd_i = ~rd; iadr_size_i = ~isz[1:0]; iadr_i = ~ia;
    wdata_i = ~wd; clk_div_i = 8'd9;
    w = 0;
    while (!done_o && w < 20000) begin
      start_i = disturb && (w == 40);
      @(negedge clk);
      w++;
    end
    start_i = 1'b0;
    chk(w < 20000, "R9", "done seen", w, 0);
    // Expected byte sequence.
    en = 0;
    if (!(rd && isz == 0)) begin e[en] = {dev, 1'b0}; en++; end
    for (int k = isz - 1; k >= 0; k--) begin e[en] = ia[8*k +: 8]; en++; end
    if (rd) e[en] = {dev, 1'b1}; else e[en] = wd;
    en++;
    f = -1;
    if (dev != s_addr) f = 0;
    else if (nack_at >= 0 && nack_at < en) f = nack_at;
    err = (f >= 0);
    if (err) en = f + 1;
    starts = (rd && isz > 0 && (!err || f >= isz + 1)) ? 2 : 1;
    chk(log_n == en, "R4", "byte count", log_n, en);
    for (int i = 0; i < en && i < log_n; i++) begin
      if (i == 0) rq = "R3";
      else if (i <= isz && !(rd && isz == 0)) rq = "R4";
      else if (rd) rq = "R5";
      else rq = "R3 R11";
      chk(mlog[i] == e[i], rq, $sformatf("byte %0d", i), mlog[i], e[i]);
    end
    chk(n_starts == starts, (rd && isz == 0) ? "R6" : "R5", "start count", n_starts, starts);
    chk(n_stops == 1, "R8", "stop count", n_stops, 1);
    chk(nack_err_o == err, "R8", "error flag", nack_err_o, err);
    if (rd && !err) begin
      prev_rdata = txb;
      chk(m_ack == 1'b1, "R7", "master NACK on read byte", m_ack, 1);
    end
    chk(rdata_o == prev_rdata, "R7", "read data", rdata_o, prev_rdata);
    chk(t_r1 - t_r0 == 4 * (dv + 1), "R10", "bit period", t_r1 - t_r0, 4 * (dv + 1));
    @(negedge clk);
    chk(done_o == 1'b0, "R9", "done width", done_o, 0);
    repeat (8) @(negedge clk);
    chk(!busy_o && !scl_oe_o && !sda_oe_o, "R1", "idle after frame", busy_o, 0);
    chk(n_starts == starts, "R1", "no extra frame", n_starts, starts);
    chk(nack_err_o == err, "R8", "error flag held", nack_err_o, err);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(!busy_o && !scl_oe_o && !sda_oe_o, "R1", "reset lines", {busy_o, scl_oe_o, sda_oe_o}, 0);
    chk(!done_o && !nack_err_o && rdata_o == 8'h00, "R9", "reset flags", {done_o, nack_err_o}, 0);
    // Directed corners.
    run_txn(7'h52, 1'b0, 0, 24'h000000, 8'hA5, 0, -1, 8'h00, 1'b0);
    run_txn(7'h52, 1'b0, 3, 24'h123456, 8'h3C, 2, -1, 8'h00, 1'b0);
    run_txn(7'h52, 1'b1, 0, 24'h000000, 8'h00, 1, -1, 8'hC3, 1'b0);
    run_txn(7'h52, 1'b1, 3, 24'hABCDEF, 8'h00, 1, -1, 8'h69, 1'b0);
    run_txn(7'h52, 1'b1, 2, 24'h00BEEF, 8'h00, 0, 3, 8'h11, 1'b0);
    run_txn(7'h13, 1'b0, 1, 24'h000077, 8'h55, 0, -1, 8'h00, 1'b0);
    run_txn(7'h52, 1'b0, 1, 24'h000077, 8'h55, 5, 2, 8'h00, 1'b0);
    run_txn(7'h52, 1'b0, 2, 24'h00A0B0, 8'hF0, 1, -1, 8'h00, 1'b1);
    run_txn(7'h52, 1'b1, 1, 24'h000042, 8'h00, 0, -1, 8'h00, 1'b1);
    // Random mix.
    for (int t = 0; t < 30; t++) begin
      logic [6:0] dv7;
      dv7 = ($urandom % 5 == 0) ? (s_addr ^ 7'(1 + $urandom % 127)) : s_addr;
      run_txn(dv7, 1'($urandom), int'($urandom % 4), 24'($urandom), 8'($urandom),
              int'($urandom % 4), ($urandom % 4 == 0) ? int'($urandom % 5) : -1,
              8'($urandom), 1'($urandom % 6 == 0));
    end
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule